// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block owns the four active-low chip-select lines of an SPI master. When the shift engine requests a transfer, the block takes a 4-bit target code. The code comes either from the static configuration (fixed selection) or from the request itself (variable selection). The block then turns the code into line levels. In direct mode each line serves one peripheral, and the lowest zero bit of the code wins. In decode mode the code is driven out raw, for an external 4-to-16 decoder.

Chip selects stay asserted between transfers. A request that names the line pattern already driven changes nothing. A request for a different pattern first releases every line. The lines are then held high for a programmable gap of at least six clocks before the new pattern is driven. While that gap runs, `ready` is low and further requests are dropped.

A loopback multiplexer feeds the serial output back to the receive path. It does this only when loopback is enabled and the master is in master mode.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset all four chip-select lines are high and `ready` is high.
- R2: In direct mode (`cfg_decode`=0), the line pattern is chosen from the lowest zero bit of the code. Codes ending in 0 give `cs_n`=1110, codes ending in 01 give 1101, codes ending in 011 give 1011, and code 0111 gives 0111.
- R3: In direct mode, code 1111 selects nothing. All lines are high, and the next accepted request is driven without a gap because no line is asserted.
- R4: In decode mode (`cfg_decode`=1), `cs_n` equals the 4-bit code exactly.
- R5: When an accepted request changes the driven pattern while some line is low, all lines go high on the next cycle. They stay high with `ready` low for exactly the effective gap in clocks, and then the new pattern appears together with `ready` high.
- R6: The effective gap is `cfg_gap` when it exceeds six, and six otherwise.
- R7: A request whose pattern equals the one already driven leaves `cs_n` unchanged and `ready` high, with no gap.
- R8: With `cfg_var_sel`=0 the code is `cfg_code`, and `xfer_code` has no effect. With `cfg_var_sel`=1 the code is `xfer_code`.
- R9: With `cfg_loopback`=1 and `cfg_master`=1, `rx_data` follows `mosi`.
- R10: When `cfg_master`=0 or `cfg_loopback`=0, `rx_data` follows `miso_pin`.
- R11: A request made while `ready` is low is ignored. The pattern driven at the end of the gap is the one from the accepted request.
- R12: The first request after reset, with no line asserted, drives its pattern on the next cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code | input | 4 | Fixed target code |
| cfg_decode | input | 1 | 1 = drive code raw for external decoder |
| cfg_gap | input | GAP_W | Programmed inter-select gap in clocks |
| cfg_var_sel | input | 1 | 1 = take code from `xfer_code` |
| cfg_loopback | input | 1 | Loopback enable |
| cfg_master | input | 1 | Master mode flag |
| xfer_req | input | 1 | Single-cycle transfer request |
| xfer_code | input | 4 | Per-transfer code (variable selection) |
| mosi | input | 1 | Serial output from the shifter |
| miso_pin | input | 1 | Serial input from the pad |
| rx_data | output | 1 | Receive data to the shifter |
| cs_n | output | 4 | Active-low chip selects |
| ready | output | 1 | High when a request may be accepted |

## Verification
The assertions assume that configuration inputs stay stable while a gap is running. They also assume that `xfer_req` is a single-cycle pulse that the shift engine raises only after sampling `ready`.

The bench changes configuration only while `ready` is high. It drives every request as a one-cycle pulse at the falling edge. The one exception is a deliberate request during a gap, which checks that such requests are dropped.

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer #(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cfg_code,
  input  logic             cfg_decode,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_var_sel,
  input  logic             cfg_loopback,
  input  logic             cfg_master,
  input  logic             xfer_req,
  input  logic [3:0]       xfer_code,
  input  logic             mosi,
  input  logic             miso_pin,
  output logic             rx_data,
  output logic [3:0]       cs_n,
  output logic             ready
);
  localparam logic [GAP_W-1:0] GapFloor = GAP_W'(MIN_GAP);
  localparam logic [3:0]       AllOff   = 4'hF;

  logic [3:0]       code_sel, direct_cs, tgt_cs, pend_cs;
  logic [GAP_W-1:0] gap_cnt, gap_eff;
  logic             accept;

  assign code_sel = cfg_var_sel ? xfer_code : cfg_code;

  always_comb begin
    casez (code_sel)
      4'b???0: direct_cs = 4'b1110;
      4'b??01: direct_cs = 4'b1101;
      4'b?011: direct_cs = 4'b1011;
      4'b0111: direct_cs = 4'b0111;
      default: direct_cs = AllOff;
    endcase
  end

  assign tgt_cs  = cfg_decode ? code_sel : direct_cs;
  assign gap_eff = (cfg_gap <= GapFloor) ? GapFloor : cfg_gap;
  assign ready   = (gap_cnt == '0);
  assign accept  = xfer_req && ready;
  assign rx_data = (cfg_loopback && cfg_master) ? mosi : miso_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= AllOff;
      pend_cs <= AllOff;
      gap_cnt <= '0;
    end else if (!ready) begin
      gap_cnt <= gap_cnt - 1'b1;
      if (gap_cnt == GAP_W'(1)) cs_n <= pend_cs;
    end else if (accept && tgt_cs != cs_n) begin
      if (cs_n == AllOff) begin
        cs_n <= tgt_cs;
      end else begin
        cs_n    <= AllOff;
        pend_cs <= tgt_cs;
        gap_cnt <= gap_eff;
      end
    end
  end

  // R5
  gap_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> cs_n == AllOff);

  // R5
  gap_end_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt == GAP_W'(1)) |=> (ready && cs_n == $past(pend_cs)));

  // R6
  gap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> gap_cnt >= GapFloor);

  // R7
  same_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tgt_cs == cs_n) |=> ($stable(cs_n) && ready));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(pend_cs));
endmodule

// File: tb/tb_spi_cs_sequencer.sv
module tb_spi_cs_sequencer;
  logic       clk = 0, rst_n = 0;
  logic [3:0] cfg_code = 0, xfer_code = 0;
  logic       cfg_decode = 0, cfg_var_sel = 0, cfg_loopback = 0, cfg_master = 0;
  logic [7:0] cfg_gap = 0;
  logic       xfer_req = 0, mosi = 0, miso_pin = 0;
  logic       rx_data, ready;
  logic [3:0] cs_n;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_cs_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .cfg_decode(cfg_decode),
    .cfg_gap(cfg_gap), .cfg_var_sel(cfg_var_sel), .cfg_loopback(cfg_loopback),
    .cfg_master(cfg_master), .xfer_req(xfer_req), .xfer_code(xfer_code),
    .mosi(mosi), .miso_pin(miso_pin), .rx_data(rx_data), .cs_n(cs_n), .ready(ready));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] direct_of(logic [3:0] c);
    if (!c[0]) return 4'b1110;
    if (!c[1]) return 4'b1101;
    if (!c[2]) return 4'b1011;
    if (!c[3]) return 4'b0111;
    return 4'b1111;
  endfunction

  // pulse a request, count gap cycles, check gap length and final pattern
  task automatic request(logic [3:0] code, logic [3:0] exp_cs, int exp_gap, string req);
    int n = 0;
    xfer_code = code; cfg_code = cfg_var_sel ? cfg_code : code;
    xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    while (!ready && n < 1000) begin
      n++;
      if (cs_n != 4'hF) check({req, " lines high in gap"}, cs_n, 4'hF);
      @(negedge clk);
    end
    check({req, " gap length"}, n, exp_gap);
    check({req, " pattern"}, cs_n, exp_cs);
  endtask

  task automatic t_reset();
    check("R1 cs_n", cs_n, 4'hF);
    check("R1 ready", ready, 1);
  endtask

  task automatic t_first();
    cfg_gap = 3;
    request(4'b0000, 4'b1110, 0, "R12 first/R2 code 0");
  endtask

  task automatic t_same();
    request(4'b1010, 4'b1110, 0, "R7 same pattern");
  endtask

  task automatic t_priority();
    request(4'b0101, direct_of(4'b0101), 6, "R2/R6 code 0101");
    request(4'b1011, direct_of(4'b1011), 6, "R2 code 1011");
    request(4'b0111, direct_of(4'b0111), 6, "R2 code 0111");
    request(4'b1111, 4'hF, 6, "R3 forbidden");
    request(4'b1001, 4'b1101, 0, "R3 no gap after forbidden");
  endtask

  task automatic t_gap();
    cfg_gap = 10; request(4'b0000, 4'b1110, 10, "R5 gap 10");
    cfg_gap = 6;  request(4'b0001, 4'b1101, 6, "R6 gap 6");
    cfg_gap = 7;  request(4'b0000, 4'b1110, 7, "R6 gap 7");
    cfg_gap = 0;  request(4'b0011, 4'b1011, 6, "R6 gap 0");
  endtask

  task automatic t_decode();
    cfg_decode = 1;
    request(4'b1010, 4'b1010, 6, "R4 raw 1010");
    request(4'b0001, 4'b0001, 6, "R4 raw 0001");
    cfg_decode = 0;
    request(4'b0000, 4'b1110, 6, "R4 back to direct");
  endtask

  task automatic t_var();
    cfg_var_sel = 1; cfg_code = 4'b0000;
    request(4'b0101, 4'b1101, 6, "R8 variable uses xfer_code");
    cfg_var_sel = 0; cfg_code = 4'b0101;
    xfer_code = 4'b0000; xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    check("R8 fixed ignores xfer_code cs", cs_n, 4'b1101);
    check("R8 fixed ignores xfer_code ready", ready, 1);
  endtask

  task automatic t_ignore();
    int n = 0;
    cfg_gap = 8; cfg_code = 4'b0011;
    xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    @(negedge clk);
    cfg_code = 4'b0111; xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    cfg_code = 4'b0011;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    check("R11 request in gap dropped", cs_n, 4'b1011);
  endtask

  task automatic t_loop();
    cfg_loopback = 1; cfg_master = 1;
    mosi = 1; miso_pin = 0; #1 check("R9 loopback high", rx_data, 1);
    mosi = 0; miso_pin = 1; #1 check("R9 loopback low", rx_data, 0);
    cfg_master = 0;
    mosi = 1; miso_pin = 0; #1 check("R10 slave ignores loopback", rx_data, 0);
    cfg_loopback = 0; cfg_master = 1;
    mosi = 0; miso_pin = 1; #1 check("R10 loopback off", rx_data, 1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first();
    t_same();
    t_priority();
    t_gap();
    t_decode();
    t_var();
    t_ignore();
    t_loop();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule